// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer arithmetic and logic unit of a 32-bit execution stage. In a single combinational pass it works out additions, subtractions (forward and reverse, with or without a carry chained in from the previous operation), bitwise logic and moves on two operands. The second operand arrives already shifted. Its carry-out arrives alongside it on a separate pin.

A 4-bit status register holds negative, zero, carry and overflow. It updates on the clock edge when the instruction asks for it. Compare and test operations always update it and never produce a writable result. Subtraction reports carry as "no borrow", so the carry-chained subtract forms take away one extra when the stored carry is clear. Multiplication, the shifter, condition evaluation and the register file sit outside the block.

Top module: `alu_flags`

## Requirements
- R1: Opcode 4 (add) gives A+B and opcode 5 (add with carry) gives A+B+C, where C is flags_o[1]. The result is taken modulo 2^32.
- R2: Opcode 2 gives A-B, opcode 3 gives B-A, opcode 6 gives A-B-(1-C) and opcode 7 gives B-A-(1-C). All results are modulo 2^32.
- R3: The bitwise opcodes are 0 (A AND B), 1 (A XOR B), 12 (A OR B), 13 (B), 14 (A AND NOT B) and 15 (NOT B).
- R4: On an update, N (flags_o[3]) takes bit 31 of the result and Z (flags_o[2]) is set exactly when the result is zero. For example, 0xFFFFFFFF+1 gives NZCV=0110 and 0x7FFFFFFF+1 gives NZCV=1001.
- R5: For arithmetic and arithmetic compare opcodes, C (flags_o[1]) is the unsigned carry-out of an addition, or the absence of a borrow for a subtraction. V (flags_o[0]) is set on signed overflow.
- R6: For bitwise, move and test opcodes, an update loads C from shift_c_i and leaves V at its previous value.
- R7: Opcodes 8 (test, A AND B), 9 (test-equivalence, A XOR B), 10 (compare, A-B) and 11 (negated compare, A+B) always update the flags and hold result_valid_o low.
- R8: Flags reset to 0000. They change only on a clock edge with set_flags_i high or with a compare opcode applied.
- R9: For non-compare opcodes, result_valid_o equals wr_en_i and result_o shows the operation result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, already shifted |
| shift_c_i | input | 1 | Shifter carry-out for bitwise ops |
| set_flags_i | input | 1 | Update flags with this operation |
| wr_en_i | input | 1 | Instruction writes a result |
| result_o | output | 32 | Operation result |
| result_valid_o | output | 1 | Result is to be written |
| flags_o | output | 4 | N, Z, C, V (bits 3..0) |

## Verification
The assertions assume that op_i, set_flags_i, wr_en_i and shift_c_i carry known values on every clock edge after reset. They also assume that result_o depends only on the current inputs and the stored carry. The stimulus meets these assumptions by driving every input with a defined value on the falling edge, one full operation per cycle. Before each test vector, a move with flag update loads a known carry, so the carry-chained forms are exercised with both carry values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_XOR   = 4'd1,
    OP_SUB   = 4'd2,
    OP_RSUB  = 4'd3,
    OP_ADD   = 4'd4,
    OP_ADDC  = 4'd5,
    OP_SUBC  = 4'd6,
    OP_RSUBC = 4'd7,
    OP_TEST  = 4'd8,
    OP_TEQV  = 4'd9,
    OP_CMP   = 4'd10,
    OP_CMPN  = 4'd11,
    OP_OR    = 4'd12,
    OP_MOV   = 4'd13,
    OP_ANDN  = 4'd14,
    OP_MOVN  = 4'd15
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int NFLAGS = 4;

  function automatic logic is_cmp(alu_op_e op);
    return op inside {OP_TEST, OP_TEQV, OP_CMP, OP_CMPN};
  endfunction

  function automatic logic is_arith(alu_op_e op);
    return op inside {OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC,
                      OP_CMP, OP_CMPN};
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH:0] full;

  assign full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o  = full[WIDTH-1:0];
  assign cout_o = full[WIDTH];
  // signed overflow: like-signed inputs, sum sign differs
  assign ovf_o  = (x_i[WIDTH-1] == y_i[WIDTH-1]) && (sum_o[WIDTH-1] != x_i[WIDTH-1]);
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 32
) (
  input  alu_pkg::alu_op_e op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  import alu_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TEST: res_o = a_i & b_i;
      OP_XOR, OP_TEQV: res_o = a_i ^ b_i;
      OP_OR:           res_o = a_i | b_i;
      OP_MOV:          res_o = b_i;
      OP_ANDN:         res_o = a_i & ~b_i;
      OP_MOVN:         res_o = ~b_i;
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [NF-1:0] d_i,
  output logic [NF-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (upd_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             shift_c_i,
  input  logic             set_flags_i,
  input  logic             wr_en_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_valid_o,
  output logic [3:0]       flags_o
);
  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic             cmp_op, arith_op, c_in;
  logic [WIDTH-1:0] add_x, add_y, add_sum, logic_res;
  logic             add_cin, add_cout, add_ovf;
  logic [NFLAGS-1:0] flags_d;

  assign op       = alu_op_e'(op_i);
  assign cmp_op   = is_cmp(op);
  assign arith_op = is_arith(op);
  assign c_in     = flags_o[FLAG_C];

  // subtraction as x + ~y + 1; carried forms use stored C in place of 1
  always_comb begin
    add_x   = a_i;
    add_y   = b_i;
    add_cin = 1'b0;
    unique case (op)
      OP_ADDC:         add_cin = c_in;
      OP_SUB, OP_CMP: begin add_y = ~b_i; add_cin = 1'b1; end
      OP_SUBC:        begin add_y = ~b_i; add_cin = c_in; end
      OP_RSUB:        begin add_x = b_i; add_y = ~a_i; add_cin = 1'b1; end
      OP_RSUBC:       begin add_x = b_i; add_y = ~a_i; add_cin = c_in; end
      default: ;
    endcase
  end

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i   (add_x),
    .y_i   (add_y),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_cout),
    .ovf_o (add_ovf)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(logic_res)
  );

  assign result_o       = arith_op ? add_sum : logic_res;
  assign result_valid_o = wr_en_i & ~cmp_op;

  always_comb begin
    flags_d[FLAG_N] = result_o[MSB];
    flags_d[FLAG_Z] = ~|result_o;
    flags_d[FLAG_C] = arith_op ? add_cout : shift_c_i;
    flags_d[FLAG_V] = arith_op ? add_ovf : flags_o[FLAG_V];
  end

  alu_flag_reg #(.NF(NFLAGS)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (set_flags_i | cmp_op),
    .d_i   (flags_d),
    .q_o   (flags_o)
  );
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       op_i,
  input logic             shift_c_i,
  input logic             set_flags_i,
  input logic             wr_en_i,
  input logic [WIDTH-1:0] result_o,
  input logic             result_valid_o,
  input logic [3:0]       flags_o
);
  logic cmp_code, logic_code, upd;

  assign cmp_code   = (op_i[3:2] == 2'b10);
  assign logic_code = (op_i inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15});
  assign upd        = set_flags_i | cmp_code;

  assert_cmp_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_code |-> !result_valid_o);

  assert_valid_follows_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_code |-> (result_valid_o == wr_en_i));

  assert_flags_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(flags_o));

  assert_nz_from_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (flags_o[3] == $past(result_o[WIDTH-1])) &&
            (flags_o[2] == ($past(result_o) == '0)));

  assert_logic_cv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && logic_code) |=> (flags_o[1] == $past(shift_c_i)) &&
                            (flags_o[0] == $past(flags_o[0])));
endmodule

bind alu_flags alu_flags_chk #(.WIDTH(WIDTH)) u_alu_flags_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .op_i          (op_i),
  .shift_c_i     (shift_c_i),
  .set_flags_i   (set_flags_i),
  .wr_en_i       (wr_en_i),
  .result_o      (result_o),
  .result_valid_o(result_valid_o),
  .flags_o       (flags_o)
);

// File: tb/tb_alu_flags.sv
module tb_alu_flags;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        shift_c_i = 1'b0, set_flags_i = 1'b0, wr_en_i = 1'b0;
  logic [31:0] result_o;
  logic        result_valid_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int failures = 0;
  logic [3:0] model_f = 4'b0000;

  always #2 clk = ~clk;

  alu_flags dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .shift_c_i(shift_c_i), .set_flags_i(set_flags_i), .wr_en_i(wr_en_i),
    .result_o(result_o), .result_valid_o(result_valid_o), .flags_o(flags_o)
  );

  logic [31:0] vals [7] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                            32'hFFFF_FFFF, 32'h1234_5678, 32'hF0F0_0F0F};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sc, input logic sf, input logic we, input bit verify);
    longint ua, ub, sa, sb, ur, sr;
    logic [31:0] res;
    logic cmp, arith, c, v, ci;
    logic [3:0] exp_f;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; shift_c_i = sc; set_flags_i = sf; wr_en_i = we;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ci = model_f[1];
    cmp = (op >= 4'd8 && op <= 4'd11);
    arith = op inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11};
    ur = 0; sr = 0; res = '0; c = sc; v = model_f[0];
    case (op)
      4'd4, 4'd11: begin ur = ua + ub; sr = sa + sb; end
      4'd5:        begin ur = ua + ub + ci; sr = sa + sb + ci; end
      4'd2, 4'd10: begin ur = ua - ub; sr = sa - sb; end
      4'd6:        begin ur = ua - ub - (1 - ci); sr = sa - sb - (1 - ci); end
      4'd3:        begin ur = ub - ua; sr = sb - sa; end
      4'd7:        begin ur = ub - ua - (1 - ci); sr = sb - sa - (1 - ci); end
      4'd0, 4'd8:  res = a & b;
      4'd1, 4'd9:  res = a ^ b;
      4'd12:       res = a | b;
      4'd13:       res = b;
      4'd14:       res = a & ~b;
      default:     res = ~b;
    endcase
    if (arith) begin
      res = ur[31:0];
      if (op inside {4'd4, 4'd5, 4'd11}) c = (ur > 64'sh0FFFF_FFFF);
      else                               c = (ur >= 0);
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end
    exp_f = (sf || cmp) ? {res[31], res == 32'h0, c, v} : model_f;
    #1;
    if (verify) begin
      if (!cmp)
        chk(result_o == res,
            (op inside {4'd4, 4'd5}) ? "R1 add result" :
            arith ? "R2 subtract result" : "R3 logic result", result_o, res);
      chk(result_valid_o == (we && !cmp), cmp ? "R7 compare valid" : "R9 valid",
          {31'b0, result_valid_o}, {31'b0, we && !cmp});
    end
    @(posedge clk); #1;
    if (verify) begin
      chk(flags_o[3:2] == exp_f[3:2], "R4 N/Z", {28'b0, flags_o}, {28'b0, exp_f});
      chk(flags_o[1:0] == exp_f[1:0],
          !(sf || cmp) ? "R8 flags held" : cmp ? "R7 compare flags" :
          arith ? "R5 arith C/V" : "R6 logic C/V", {28'b0, flags_o}, {28'b0, exp_f});
    end
    model_f = flags_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(flags_o == 4'b0000, "R8 reset flags", {28'b0, flags_o}, 32'h0);
    chk(result_valid_o == 1'b0, "R9 reset valid", {31'b0, result_valid_o}, 32'h0);
    @(negedge clk); rst_ni = 1'b1;
    // named corner cases for R4
    step(4'd13, 32'h0, 32'h1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(4'd4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(flags_o == 4'b0110, "R4 -1+1 NZCV", {28'b0, flags_o}, 32'h6);
    step(4'd4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(flags_o == 4'b1001, "R4 max+1 NZCV", {28'b0, flags_o}, 32'h9);
    for (int op = 0; op < 16; op++)
      for (int ai = 0; ai < 7; ai++)
        for (int bi = 0; bi < 7; bi++)
          for (int cin = 0; cin < 2; cin++)
            for (int sf = 0; sf < 2; sf++) begin
              step(4'd13, 32'h0, 32'h1, cin[0], 1'b1, 1'b0, 1'b0);
              step(op[3:0], vals[ai], vals[bi], ai[0] ^ bi[0], sf[0],
                   (ai[1] ^ sf[0]), 1'b1);
            end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule